// File: doc/BRIEF.md
# Streaming DC Removal Filter

This block strips the constant offset from a stream of signed two's-complement samples. It accepts one sample on any clock cycle where the input qualifier is high and is built for sample rates equal to the clock rate. The filter is a first-order high-pass with transfer function (1 − z⁻¹)/(1 − p·z⁻¹). The pole is p = 1 − 2^-K. The product with the pole is formed from an arithmetic shift and a subtraction, so the recursive loop closes within a single clock and no multiplier is used.

A build-time parameter selects one of two arithmetic forms. The accumulator form keeps a wide low-pass state and subtracts its floor from the input. Nothing is truncated inside that loop. The error-feedback form runs the differentiator and pole recursion directly. It quantizes the recursive result back to integers, and the remainder discarded by each quantization is carried into the next sum. Both forms drive a registered high-pass output and the matching low-pass (offset estimate) output, each saturated to the sample width.

Top module: `dc_blocker`

## Requirements
- R1: While `rst_n` is low at a rising edge, all filter state is cleared, and after that edge `out_valid` is 0 and `hp_out` and `lp_out` are 0.
- R2: `out_valid` equals `in_valid` delayed by one clock. A cycle with `in_valid` low changes neither the filter state nor `hp_out` or `lp_out`.
- R3: With MODE = DCB_ACCUM (value 0), the state is a signed accumulator A, where A/2^K is the low-pass value. For each valid sample x, the block forms L = floor(A / 2^K) and H = x − L. It then presents sat(H) on `hp_out` and updates A to A + H, using the unsaturated H.
- R4: With MODE = DCB_ERRFB (value 1), the state is the previous input xp, an integer y and a remainder r in [0, 2^K). For each valid sample x, the block forms v = (x − xp)·2^K + (2^K − 1)·y + r. The new y is floor(v / 2^K), the new r is v − y·2^K, xp becomes x, and `hp_out` is sat(y).
- R5: After a constant input has been held for 64·2^K samples, |`hp_out`| ≤ 2 in both modes.
- R6: For a sinusoid of amplitude 30000 and period 16 samples, with K = 8, the RMS ratio of `hp_out` to the input, measured once the start-up transient has died away, lies within 1% of unity in both modes.
- R7: `lp_out` is sat(L) in MODE 0 and sat(x − y) in MODE 1. When neither output is clipped, `hp_out` + `lp_out` equals the sample that produced them.
- R8: sat() clamps to [−2^(DW−1), 2^(DW−1) − 1]. A full-scale upward step from −32768 to +32767 yields `hp_out` = +32767 in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample may enter per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Marks a new result on the outputs |
| hp_out | output | DW | Offset-free sample, saturated |
| lp_out | output | DW | Current offset estimate, saturated |

## Verification
In the accumulator form, a wrong accumulator value shows up in `lp_out` in the very next valid result. It then spreads into `hp_out`, so an exact per-sample comparison catches it within one sample. In the error-feedback form, a lost remainder or a wrong stored input changes `hp_out` by only one or a few LSBs. The change appears in the result after the faulty update and persists, so only a bit-exact comparison of every sample exposes it; the amplitude checks would miss it. State that fails to hold during idle cycles shows as an output that moves while `out_valid` is low, or as a mismatch on the next valid sample.

// File: rtl/dcb_pkg.sv
// Shared definitions for the DC removal filter.
// Assumes: nothing beyond IEEE 1800-2017.
package dcb_pkg;
    // Arithmetic form of the recursive section
    typedef enum logic {
        DCB_ACCUM = 1'b0,  // wide low-pass accumulator, no in-loop truncation
        DCB_ERRFB = 1'b1   // direct recursion with remainder feedback
    } dcb_mode_e;
endpackage

// File: rtl/dcb_sat.sv
// Clamps a wide signed value to a narrower signed range.
// Assumes: IW > OW.
module dcb_sat #(
    parameter int IW = 19,
    parameter int OW = 16
) (
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout
);
    localparam logic signed [IW-1:0] MAXV = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [IW-1:0] MINV = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    // Select the clamp bound or pass the low bits through
    always_comb begin
        if (din > MAXV)      dout = MAXV[OW-1:0];
        else if (din < MINV) dout = MINV[OW-1:0];
        else                 dout = din[OW-1:0];
    end
endmodule

// File: rtl/dcb_pole_shift.sv
// Forms (2^K - 1)*y, the pole product scaled by 2^K, with one shift and one subtract.
// Assumes: the result width W+K+1 cannot overflow for any W-bit input.
module dcb_pole_shift #(
    parameter int W = 18,
    parameter int K = 8
) (
    input  logic signed [W-1:0] y,
    output logic signed [W+K:0] py
);
    logic signed [W+K:0] y_up;
    logic signed [W+K:0] y_ext;

    // Shifted copy minus plain copy
    always_comb begin
        y_up  = {y[W-1], y, {K{1'b0}}};
        y_ext = {{(K+1){y[W-1]}}, y};
        py    = y_up - y_ext;
    end
endmodule

// File: rtl/dcb_accum_loop.sv
// Accumulator form: high-pass = x - floor(state / 2^K); the state then grows by the high-pass value.
// The loop holds the low-pass value at K fractional bits and never truncates.
// Assumes: K >= 2; the input stays within DW bits.
module dcb_accum_loop #(
    parameter int DW = 16,
    parameter int GW = 2,
    parameter int K  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] x,
    output logic signed [DW+GW:0] hp_w,
    output logic signed [DW+GW:0] lp_w
);
    localparam int LW = DW + GW;
    localparam int AW = LW + K;

    logic signed [AW-1:0] acc_q;
    logic signed [LW-1:0] lp_int;

    // Integer part of the low-pass state and the resulting high-pass value
    always_comb begin
        lp_int = acc_q[AW-1:K];
        lp_w   = {lp_int[LW-1], lp_int};
        hp_w   = {{(GW+1){x[DW-1]}}, x} - lp_w;
    end

    // Integrate the high-pass value into the low-pass state
    always_ff @(posedge clk) begin
        if (!rst_n)  acc_q <= '0;
        else if (en) acc_q <= acc_q + {{(AW-LW-1){hp_w[LW]}}, hp_w};
    end
endmodule

// File: rtl/dcb_errfb_loop.sv
// Error-feedback form: differentiator, then pole recursion quantized by floor.
// The discarded fraction is added into the next sum.
// Assumes: the integer state fits in DW+GW bits for the applied inputs.
module dcb_errfb_loop #(
    parameter int DW = 16,
    parameter int GW = 2,
    parameter int K  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] x,
    output logic signed [DW+GW:0] hp_w,
    output logic signed [DW+GW:0] lp_w
);
    localparam int LW = DW + GW;
    localparam int VW = LW + K + 2;

    logic signed [DW-1:0] x_q;
    logic signed [LW-1:0] y_q;
    logic        [K-1:0]  r_q;
    logic signed [DW:0]   diff;
    logic signed [LW+K:0] py;
    logic signed [VW-1:0] v;
    logic signed [LW-1:0] y_n;

    dcb_pole_shift #(.W(LW), .K(K)) u_pole (
        .y  (y_q),
        .py (py)
    );

    // Unquantized sum at K fractional bits, its floor, and both outputs
    always_comb begin
        diff = {x[DW-1], x} - {x_q[DW-1], x_q};
        v    = {{(GW+1){diff[DW]}}, diff, {K{1'b0}}}
             + {py[LW+K], py}
             + {{(VW-K){1'b0}}, r_q};
        y_n  = v[LW+K-1:K];
        hp_w = {y_n[LW-1], y_n};
        lp_w = {{(GW+1){x[DW-1]}}, x} - hp_w;
    end

    // Store previous input, quantized output and remainder
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
            r_q <= '0;
        end else if (en) begin
            x_q <= x;
            y_q <= y_n;
            r_q <= v[K-1:0];
        end
    end
endmodule

// File: rtl/dc_blocker.sv
// DC removal filter, one sample per clock, pole 1 - 2^-K.
// MODE selects the arithmetic form; the outputs are registered and saturated.
// Assumes: synchronous active-low reset; K >= 2; GW >= 1.
module dc_blocker #(
    parameter int               DW   = 16,
    parameter int               GW   = 2,
    parameter int               K    = 8,
    parameter dcb_pkg::dcb_mode_e MODE = dcb_pkg::DCB_ACCUM
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    output logic signed [DW-1:0] hp_out,
    output logic signed [DW-1:0] lp_out
);
    localparam int LW = DW + GW;

    logic signed [LW:0]   hp_w;
    logic signed [LW:0]   lp_w;
    logic signed [DW-1:0] hp_s;
    logic signed [DW-1:0] lp_s;

    generate
        if (MODE == dcb_pkg::DCB_ERRFB) begin : g_errfb
            dcb_errfb_loop #(.DW(DW), .GW(GW), .K(K)) u_loop (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (in_valid),
                .x     (in_data),
                .hp_w  (hp_w),
                .lp_w  (lp_w)
            );
        end else begin : g_accum
            dcb_accum_loop #(.DW(DW), .GW(GW), .K(K)) u_loop (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (in_valid),
                .x     (in_data),
                .hp_w  (hp_w),
                .lp_w  (lp_w)
            );
        end
    endgenerate

    dcb_sat #(.IW(LW+1), .OW(DW)) u_sat_hp (.din(hp_w), .dout(hp_s));
    dcb_sat #(.IW(LW+1), .OW(DW)) u_sat_lp (.din(lp_w), .dout(lp_s));

    // Output register: new result on valid, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            hp_out    <= '0;
            lp_out    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                hp_out <= hp_s;
                lp_out <= lp_s;
            end
        end
    end
endmodule

// File: rtl/dcb_chk.sv
// Port-level properties of the DC removal filter, bound into every instance.
// Assumes: the reset is held low for at least one edge before use.
module dcb_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_data,
    input logic                 out_valid,
    input logic signed [DW-1:0] hp_out,
    input logic signed [DW-1:0] lp_out
);
    localparam logic signed [DW-1:0] TOP = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] BOT = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW:0] pair_sum;
    logic               unclipped;

    // Sum of both outputs and a flag that neither sits at a rail
    always_comb begin
        pair_sum  = {hp_out[DW-1], hp_out} + {lp_out[DW-1], lp_out};
        unclipped = (hp_out != TOP) && (hp_out != BOT) && (lp_out != TOP) && (lp_out != BOT);
    end

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R2
    idle_hold_hp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(hp_out));

    // R2
    idle_hold_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(lp_out));

    // R7
    sum_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && unclipped) |-> pair_sum == {$past(in_data[DW-1]), $past(in_data)});
endmodule

bind dc_blocker dcb_chk #(.DW(DW)) u_dcb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .hp_out    (hp_out),
    .lp_out    (lp_out)
);

// File: tb/test_dc_blocker.sv
`timescale 1ns/1ps
module test_dc_blocker;
    localparam int DW = 16;
    localparam int K  = 8;

    typedef struct {
        int hp;
        int lp;
        bit meas;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic ov_a, ov_b;
    logic signed [DW-1:0] hp_a, lp_a, hp_b, lp_b;

    exp_t q_a[$];
    exp_t q_b[$];
    int   m_chk = 0, m_fail = 0, t_chk = 0, t_fail = 0, w_fail = 0;
    int   last_hp_a = 0, last_hp_b = 0;
    real  eo_a = 0.0, eo_b = 0.0, ein = 0.0;
    bit   done = 0;
    longint acc_m = 0, yq_m = 0, r_m = 0, xp_m = 0;

    always #4 clk = ~clk;

    dc_blocker #(.DW(DW), .GW(2), .K(K), .MODE(dcb_pkg::DCB_ACCUM)) i_dc_blocker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov_a), .hp_out(hp_a), .lp_out(lp_a)
    );

    dc_blocker #(.DW(DW), .GW(2), .K(K), .MODE(dcb_pkg::DCB_ERRFB)) i_dc_blocker_ef (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(ov_b), .hp_out(hp_b), .lp_out(lp_b)
    );

    function automatic int clamp(longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic bit cmp(string req, string what, int act, int exp);
        if (act != exp) $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        return act == exp;
    endfunction

    // Driver: compute both reference models (R3, R4, R7), queue results, drive one sample
    task automatic send(input int x, input bit meas);
        exp_t   e;
        longint lpi, hpw, v, yn;
        lpi = acc_m >>> K;
        hpw = longint'(x) - lpi;
        e.hp = clamp(hpw); e.lp = clamp(lpi); e.meas = meas;
        q_a.push_back(e);
        acc_m = acc_m + hpw;
        v  = (longint'(x) - xp_m) * (longint'(1) <<< K) + yq_m * ((longint'(1) <<< K) - 1) + r_m;
        yn = v >>> K;
        r_m  = v - (yn <<< K);
        yq_m = yn;
        xp_m = longint'(x);
        e.hp = clamp(yn); e.lp = clamp(longint'(x) - yn);
        q_b.push_back(e);
        if (meas) ein = ein + real'(x) * real'(x);
        in_valid = 1'b1;
        in_data  = DW'(x);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // R1: outputs cleared while reset is applied
    task automatic check_reset_state();
        t_chk++; if (!cmp("R1", "accum valid", int'(ov_a), 0)) t_fail++;
        t_chk++; if (!cmp("R1", "accum hp", hp_a, 0)) t_fail++;
        t_chk++; if (!cmp("R1", "accum lp", lp_a, 0)) t_fail++;
        t_chk++; if (!cmp("R1", "errfb valid", int'(ov_b), 0)) t_fail++;
        t_chk++; if (!cmp("R1", "errfb hp", hp_b, 0)) t_fail++;
        t_chk++; if (!cmp("R1", "errfb lp", lp_b, 0)) t_fail++;
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state();
        acc_m = 0; yq_m = 0; r_m = 0; xp_m = 0;
        q_a.delete(); q_b.delete();
        rst_n = 1'b1;
    endtask

    // Monitor: pop expected items and compare as results appear
    always @(negedge clk) begin
        exp_t ea, eb;
        if (!rst_n) begin
            last_hp_a = 0; last_hp_b = 0;
        end else begin
            if (ov_a) begin
                if (q_a.size() == 0) begin
                    m_chk++; m_fail++;
                    $display("FAIL R2 accum valid: actual 1 expected 0");
                end else begin
                    ea = q_a.pop_front();
                    m_chk++; if (!cmp("R3", "accum hp", hp_a, ea.hp)) m_fail++;
                    m_chk++; if (!cmp("R7", "accum lp", lp_a, ea.lp)) m_fail++;
                    if (ea.meas) eo_a = eo_a + real'(hp_a) * real'(hp_a);
                end
                last_hp_a = hp_a;
            end else begin
                m_chk++; if (!cmp("R2", "accum idle hold", hp_a, last_hp_a)) m_fail++;
            end
            if (ov_b) begin
                if (q_b.size() == 0) begin
                    m_chk++; m_fail++;
                    $display("FAIL R2 errfb valid: actual 1 expected 0");
                end else begin
                    eb = q_b.pop_front();
                    m_chk++; if (!cmp("R4", "errfb hp", hp_b, eb.hp)) m_fail++;
                    m_chk++; if (!cmp("R7", "errfb lp", lp_b, eb.lp)) m_fail++;
                    if (eb.meas) eo_b = eo_b + real'(hp_b) * real'(hp_b);
                end
                last_hp_b = hp_b;
            end else begin
                m_chk++; if (!cmp("R2", "errfb idle hold", hp_b, last_hp_b)) m_fail++;
            end
        end
    end

    // Main sequence
    initial begin
        logic [15:0] lfsr;
        real ra, rb;
        lfsr = 16'hACE1;
        repeat (4) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;

        // R2 R3 R4: pseudo-random samples with idle gaps
        for (int i = 0; i < 300; i++) begin
            lfsr = (lfsr >> 1) ^ (lfsr[0] ? 16'hB400 : 16'h0000);
            if (i % 7 == 3) idle(1 + i % 3);
            send(int'($signed(lfsr)) >>> 2, 1'b0);
        end
        // R3 R4: sawtooth ramp
        for (int i = 0; i < 200; i++) send(((i * 97) % 32000) - 16000, 1'b0);
        idle(3);

        // R1: reset in mid-run
        do_reset();

        // R5: constant input decays
        repeat (64 << K) send(12345, 1'b0);
        idle(3);
        t_chk++; if (!cmp("R5", "accum residual within 2", int'(last_hp_a > 2 || last_hp_a < -2), 0)) t_fail++;
        t_chk++; if (!cmp("R5", "errfb residual within 2", int'(last_hp_b > 2 || last_hp_b < -2), 0)) t_fail++;

        // R8: full-scale upward step clamps
        repeat (16 << K) send(-32768, 1'b0);
        send(32767, 1'b0);
        idle(3);
        t_chk++; if (!cmp("R8", "accum step clamp", last_hp_a, 32767)) t_fail++;
        t_chk++; if (!cmp("R8", "errfb step clamp", last_hp_b, 32767)) t_fail++;

        // R6: passband gain of a sinusoid
        do_reset();
        for (int n = 0; n < 3072; n++)
            send($rtoi(30000.0 * $sin(6.283185307179586 * real'(n) / 16.0)), n >= 2048);
        idle(3);
        ra = $sqrt(eo_a / ein);
        rb = $sqrt(eo_b / ein);
        t_chk++;
        if (ra < 0.99 || ra > 1.01) begin
            t_fail++; $display("FAIL R6 accum gain: actual %f expected 1.00 +/- 0.01", ra);
        end
        t_chk++;
        if (rb < 0.99 || rb > 1.01) begin
            t_fail++; $display("FAIL R6 errfb gain: actual %f expected 1.00 +/- 0.01", rb);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", m_chk + t_chk, m_fail + t_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            w_fail = 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", m_chk + t_chk + 1, m_fail + t_fail + w_fail);
            $finish;
        end
    end
endmodule